// File: doc/BRIEF.md
# Block-Sparse Matrix-Vector Multiply Engine

This engine computes y = y + A·x for a sparse integer matrix A held in block compressed sparse row form. The block height and width are fixed by parameters. Three read-only memories describe the matrix: one table gives, for each block row, where its list of blocks begins; a second gives each stored block's leftmost column; a third holds the block values, packed back to back. The source vector x is read from its own memory. The destination vector y is read, updated and written back through a further port. Every memory port has a synchronous read with one cycle of latency.

For each block row, the engine first loads the block row's r destination elements into r accumulators. For each stored block, it then loads the c source elements that the block covers into local registers and issues the r×c multiply-accumulates. When the block row ends, it writes the r sums back once. Zeros that pad a partly filled block are multiplied like any other value. The useful-operation count therefore comes from a nonzero count that is supplied with the start request. A cycle counter covers the run, so the two counts can be related.

Top module: `bsmv_engine`

## Requirements
- R1: After a run, for every block row b below the latched row count and every i < R_BLK, y[b·R_BLK+i] equals its old value plus the sum, over the block row's stored blocks and j < C_BLK, of value × x[col+j]. Values and x are signed 16-bit; y is 32-bit.
- R2: Block k's values sit at value addresses k·R_BLK·C_BLK + i·C_BLK + j (row i, column j within the block). Its column-index entry is the absolute column of its top-left element, which need not be a multiple of C_BLK.
- R3: Block row b owns blocks ptr[b] up to ptr[b+1]−1. A block row with equal consecutive pointers leaves its y elements unchanged.
- R4: op_count equals twice the nnz_in value sampled at the accepted start, whatever explicit zeros the blocks contain, and holds during the run.
- R5: Accumulation wraps modulo 2^32. For example, two products of (−32768)·(−32768) added to 5 give 32'h80000005.
- R6: done is high for exactly one cycle, the cycle after the last write-back, and busy stays high from the cycle after an accepted start through the done cycle.
- R7: A start pulse while busy is ignored. nbrows and nnz_in are sampled only at an accepted start.
- R8: After done, cycle_count equals 1 + Σ over block rows of (2·R_BLK + 4 + nb·(R_BLK·C_BLK + C_BLK + 4)), where nb is the block row's block count.
- R9: Each destination element of the processed block rows is written exactly once per run, and no element beyond them is written. dst_we is never high outside busy.
- R10: After reset, busy, done and dst_we are low, and op_count and cycle_count are zero.
- R11: A start with nbrows = 0 gives done on the following cycle with no writes and cycle_count = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, accepted only while idle |
| nbrows | input | PTR_AW | Number of block rows, sampled at start |
| nnz_in | input | NNZ_W | Original nonzero count, sampled at start |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| op_count | output | NNZ_W+1 | Useful operations (2 per nonzero) |
| cycle_count | output | CYC_W | Cycles spent in the last run |
| ptr_addr | output | PTR_AW | Block-row pointer memory address |
| ptr_rdata | input | BLK_AW | Block-row pointer read data |
| cidx_addr | output | BLK_AW | Block column memory address |
| cidx_rdata | input | XA_W | Block column read data |
| val_addr | output | VAL_AW | Value memory address |
| val_rdata | input | VAL_W | Value read data |
| src_addr | output | XA_W | Source vector address |
| src_rdata | input | VAL_W | Source vector read data |
| dst_addr | output | YA_W | Destination vector address |
| dst_rdata | input | ACC_W | Destination vector read data |
| dst_we | output | 1 | Destination write enable |
| dst_wdata | output | ACC_W | Destination write data |

## Verification
The hardest situation to bring about from the ports is a start pulse that lands in the middle of a run, carrying a different row count and nonzero count. The stimulus table holds a flag that raises start with nbrows = 0 and an all-ones nonzero count a few cycles after a real start. The bench then checks that the results, the write counts, the single done pulse, the cycle count and the operation count all match the original request. Empty block rows, unaligned block columns and accumulator wrap-around are built deliberately: through presence masks in the table, a seed-chosen column offset, and a directed extreme-value block.

// File: rtl/bsmv_pkg.sv
`timescale 1ns/1ps
package bsmv_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PLO,
      ST_PHI,
      ST_YLD,
      ST_BCHK,
      ST_CIDX,
      ST_XLD,
      ST_MAC,
      ST_WB,
      ST_DONE
   } bsmv_state_e;
endpackage

// File: rtl/bsmv_ctrl.sv
`timescale 1ns/1ps
module bsmv_ctrl
   import bsmv_pkg::*;
#(
   parameter int R_BLK  = 2,
   parameter int C_BLK  = 2,
   parameter int PTR_AW = 4,
   parameter int BLK_AW = 6,
   parameter int VAL_AW = 8,
   parameter int XA_W   = 6,
   parameter int YA_W   = 6,
   parameter int NNZ_W  = 12,
   parameter int CYC_W  = 20,
   parameter int RIW    = 1,
   parameter int CIW    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PTR_AW-1:0] nbrows,
   input  logic [NNZ_W-1:0]  nnz,
   input  logic [BLK_AW-1:0] ptr_rdata,
   input  logic [XA_W-1:0]   cidx_rdata,
   output logic [PTR_AW-1:0] ptr_addr,
   output logic [BLK_AW-1:0] cidx_addr,
   output logic [VAL_AW-1:0] val_addr,
   output logic [XA_W-1:0]   src_addr,
   output logic [YA_W-1:0]   dst_addr,
   output logic              dst_we,
   output logic              x_we,
   output logic [CIW-1:0]    x_widx,
   output logic [CIW-1:0]    x_ridx,
   output logic              acc_ld,
   output logic [RIW-1:0]    acc_lidx,
   output logic              mac_en,
   output logic [RIW-1:0]    mac_row,
   output logic [RIW-1:0]    acc_ridx,
   output logic              busy,
   output logic              done,
   output logic [NNZ_W:0]    op_count,
   output logic [CYC_W-1:0]  cycle_count
);
   localparam int RC = R_BLK * C_BLK;
   localparam int CW = $clog2(RC + 2);
   localparam logic [CW-1:0]  R_C    = CW'(R_BLK);
   localparam logic [CW-1:0]  C_C    = CW'(C_BLK);
   localparam logic [CW-1:0]  RC_C   = CW'(RC);
   localparam logic [CW-1:0]  R_LAST = CW'(R_BLK - 1);
   localparam logic [CIW-1:0] C_LAST = CIW'(C_BLK - 1);

   bsmv_state_e       st;
   logic [PTR_AW-1:0] brow, nbr_q;
   logic [BLK_AW-1:0] blk, blk_end;
   logic [XA_W-1:0]   col;
   logic [YA_W-1:0]   ybase;
   logic [CW-1:0]     cnt, cnt_m1;
   logic [RIW-1:0]    cap_r;
   logic [CIW-1:0]    cap_c;
   logic [NNZ_W:0]    ops_q;
   logic [CYC_W-1:0]  cyc_q;

   // address and strobe decode from the walk state
   assign cnt_m1      = cnt - CW'(1);
   assign ptr_addr    = (st == ST_PHI) ? brow + PTR_AW'(1) : brow;
   assign cidx_addr   = blk;
   assign val_addr    = VAL_AW'(blk) * VAL_AW'(RC) + VAL_AW'(cnt);
   assign src_addr    = col + XA_W'(cnt);
   assign dst_addr    = ybase + YA_W'(cnt);
   assign dst_we      = (st == ST_WB);
   assign x_we        = (st == ST_XLD) && (cnt != '0);
   assign x_widx      = CIW'(cnt_m1);
   assign x_ridx      = cap_c;
   assign acc_ld      = (st == ST_YLD) && (cnt != '0);
   assign acc_lidx    = RIW'(cnt_m1);
   assign mac_en      = (st == ST_MAC) && (cnt != '0);
   assign mac_row     = cap_r;
   assign acc_ridx    = RIW'(cnt);
   assign busy        = (st != ST_IDLE);
   assign done        = (st == ST_DONE);
   assign op_count    = ops_q;
   assign cycle_count = cyc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         brow    <= '0;
         nbr_q   <= '0;
         blk     <= '0;
         blk_end <= '0;
         col     <= '0;
         ybase   <= '0;
         cnt     <= '0;
         cap_r   <= '0;
         cap_c   <= '0;
         ops_q   <= '0;
         cyc_q   <= '0;
      end else begin
         if (st != ST_IDLE) cyc_q <= cyc_q + CYC_W'(1);
         case (st)
            ST_IDLE: begin
               if (start) begin
                  nbr_q <= nbrows;
                  brow  <= '0;
                  ybase <= '0;
                  cnt   <= '0;
                  ops_q <= {nnz, 1'b0};
                  cyc_q <= '0;
                  st    <= (nbrows == '0) ? ST_DONE : ST_PLO;
               end
            end
            ST_PLO: st <= ST_PHI;
            ST_PHI: begin
               blk <= ptr_rdata;
               cnt <= '0;
               st  <= ST_YLD;
            end
            ST_YLD: begin
               if (cnt == '0) blk_end <= ptr_rdata;
               if (cnt == R_C) begin
                  cnt <= '0;
                  st  <= ST_BCHK;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            ST_BCHK: begin
               cnt <= '0;
               st  <= (blk == blk_end) ? ST_WB : ST_CIDX;
            end
            ST_CIDX: begin
               col <= cidx_rdata;
               cnt <= '0;
               st  <= ST_XLD;
            end
            ST_XLD: begin
               if (cnt == C_C) begin
                  cnt   <= '0;
                  cap_r <= '0;
                  cap_c <= '0;
                  st    <= ST_MAC;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            ST_MAC: begin
               if (cnt != '0) begin
                  if (cap_c == C_LAST) begin
                     cap_c <= '0;
                     cap_r <= cap_r + RIW'(1);
                  end else begin
                     cap_c <= cap_c + CIW'(1);
                  end
               end
               if (cnt == RC_C) begin
                  cnt <= '0;
                  blk <= blk + BLK_AW'(1);
                  st  <= ST_BCHK;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            ST_WB: begin
               if (cnt == R_LAST) begin
                  cnt <= '0;
                  if (brow == nbr_q - PTR_AW'(1)) begin
                     st <= ST_DONE;
                  end else begin
                     brow  <= brow + PTR_AW'(1);
                     ybase <= ybase + YA_W'(R_BLK);
                     st    <= ST_PLO;
                  end
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bsmv_srcbuf.sv
`timescale 1ns/1ps
module bsmv_srcbuf #(
   parameter int C_BLK = 2,
   parameter int VAL_W = 16,
   parameter int CIW   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CIW-1:0]   wr_idx,
   input  logic [VAL_W-1:0] wr_data,
   input  logic [CIW-1:0]   rd_idx,
   output logic [VAL_W-1:0] rd_data
);
   if (C_BLK == 1) begin : g_single
      logic [VAL_W-1:0] xr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     xr <= '0;
         else if (wr_en) xr <= wr_data;
      end
      assign rd_data = xr;
   end else begin : g_multi
      logic [VAL_W-1:0] xv [C_BLK];
      for (genvar g = 0; g < C_BLK; g++) begin : g_el
         logic [VAL_W-1:0] xr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                xr <= '0;
            else if (wr_en && (wr_idx == CIW'(g)))     xr <= wr_data;
         end
         assign xv[g] = xr;
      end
      assign rd_data = xv[rd_idx];
   end
endmodule

// File: rtl/bsmv_accbank.sv
`timescale 1ns/1ps
module bsmv_accbank #(
   parameter int R_BLK = 2,
   parameter int VAL_W = 16,
   parameter int ACC_W = 32,
   parameter int RIW   = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ld_en,
   input  logic [RIW-1:0]          ld_idx,
   input  logic [ACC_W-1:0]        ld_data,
   input  logic                    mac_en,
   input  logic [RIW-1:0]          mac_row,
   input  logic signed [VAL_W-1:0] mul_a,
   input  logic signed [VAL_W-1:0] mul_b,
   input  logic [RIW-1:0]          rd_idx,
   output logic [ACC_W-1:0]        rd_data
);
   localparam int PW = 2 * VAL_W;

   logic signed [PW-1:0] prod;
   logic [ACC_W-1:0]     prod_x;
   logic [ACC_W-1:0]     accv [R_BLK];

   assign prod = mul_a * mul_b;

   if (ACC_W == PW) begin : g_ext_none
      assign prod_x = prod;
   end else begin : g_ext_sign
      assign prod_x = {{(ACC_W - PW){prod[PW-1]}}, prod};
   end

   for (genvar g = 0; g < R_BLK; g++) begin : g_row
      logic [ACC_W-1:0] ar;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  ar <= '0;
         else if (ld_en && (ld_idx == RIW'(g)))       ar <= ld_data;
         else if (mac_en && (mac_row == RIW'(g)))     ar <= ar + prod_x;
      end
      assign accv[g] = ar;
   end

   assign rd_data = accv[rd_idx];
endmodule

// File: rtl/bsmv_engine.sv
`timescale 1ns/1ps
module bsmv_engine #(
   parameter int R_BLK  = 2,
   parameter int C_BLK  = 2,
   parameter int VAL_W  = 16,
   parameter int ACC_W  = 32,
   parameter int PTR_AW = 4,
   parameter int BLK_AW = 6,
   parameter int VAL_AW = 8,
   parameter int XA_W   = 6,
   parameter int YA_W   = 6,
   parameter int NNZ_W  = 12,
   parameter int CYC_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PTR_AW-1:0] nbrows,
   input  logic [NNZ_W-1:0]  nnz_in,
   output logic              busy,
   output logic              done,
   output logic [NNZ_W:0]    op_count,
   output logic [CYC_W-1:0]  cycle_count,
   output logic [PTR_AW-1:0] ptr_addr,
   input  logic [BLK_AW-1:0] ptr_rdata,
   output logic [BLK_AW-1:0] cidx_addr,
   input  logic [XA_W-1:0]   cidx_rdata,
   output logic [VAL_AW-1:0] val_addr,
   input  logic [VAL_W-1:0]  val_rdata,
   output logic [XA_W-1:0]   src_addr,
   input  logic [VAL_W-1:0]  src_rdata,
   output logic [YA_W-1:0]   dst_addr,
   input  logic [ACC_W-1:0]  dst_rdata,
   output logic              dst_we,
   output logic [ACC_W-1:0]  dst_wdata
);
   localparam int RIW = (R_BLK > 1) ? $clog2(R_BLK) : 1;
   localparam int CIW = (C_BLK > 1) ? $clog2(C_BLK) : 1;

   // elaboration-time parameter checks
   if (R_BLK < 1 || C_BLK < 1) begin : g_bad_blk
      $error("block dimensions must be at least 1");
   end
   if (ACC_W < 2 * VAL_W) begin : g_bad_acc
      $error("accumulator narrower than a full product");
   end
   if (VAL_AW < BLK_AW + $clog2(R_BLK * C_BLK)) begin : g_bad_val
      $error("value address too narrow for block count");
   end
   if (YA_W < PTR_AW + RIW) begin : g_bad_dst
      $error("destination address too narrow for block rows");
   end

   logic              x_we, acc_ld, mac_en;
   logic [CIW-1:0]    x_widx, x_ridx;
   logic [RIW-1:0]    acc_lidx, mac_row, acc_ridx;
   logic [VAL_W-1:0]  x_cur;

   bsmv_ctrl #(
      .R_BLK(R_BLK), .C_BLK(C_BLK), .PTR_AW(PTR_AW), .BLK_AW(BLK_AW),
      .VAL_AW(VAL_AW), .XA_W(XA_W), .YA_W(YA_W), .NNZ_W(NNZ_W),
      .CYC_W(CYC_W), .RIW(RIW), .CIW(CIW)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .nbrows(nbrows), .nnz(nnz_in),
      .ptr_rdata(ptr_rdata), .cidx_rdata(cidx_rdata),
      .ptr_addr(ptr_addr), .cidx_addr(cidx_addr), .val_addr(val_addr),
      .src_addr(src_addr), .dst_addr(dst_addr), .dst_we(dst_we),
      .x_we(x_we), .x_widx(x_widx), .x_ridx(x_ridx),
      .acc_ld(acc_ld), .acc_lidx(acc_lidx), .mac_en(mac_en),
      .mac_row(mac_row), .acc_ridx(acc_ridx),
      .busy(busy), .done(done), .op_count(op_count), .cycle_count(cycle_count)
   );

   bsmv_srcbuf #(.C_BLK(C_BLK), .VAL_W(VAL_W), .CIW(CIW)) u_xbuf (
      .clk(clk), .rst_n(rst_n), .wr_en(x_we), .wr_idx(x_widx),
      .wr_data(src_rdata), .rd_idx(x_ridx), .rd_data(x_cur)
   );

   bsmv_accbank #(.R_BLK(R_BLK), .VAL_W(VAL_W), .ACC_W(ACC_W), .RIW(RIW)) u_acc (
      .clk(clk), .rst_n(rst_n), .ld_en(acc_ld), .ld_idx(acc_lidx),
      .ld_data(dst_rdata), .mac_en(mac_en), .mac_row(mac_row),
      .mul_a(val_rdata), .mul_b(x_cur), .rd_idx(acc_ridx), .rd_data(dst_wdata)
   );
endmodule

// File: rtl/bsmv_chk.sv
`timescale 1ns/1ps
module bsmv_chk #(
   parameter int OPS_W = 13
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic             dst_we,
   input logic [OPS_W-1:0] op_count
);
   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   done_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   // R9
   write_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dst_we |-> (busy && !done));

   // R7
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && start) |=> busy);

   // R4
   ops_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(op_count));
endmodule

bind bsmv_engine bsmv_chk #(.OPS_W(NNZ_W + 1)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .dst_we(dst_we), .op_count(op_count)
);

// File: tb/tb_bsmv_engine.sv
`timescale 1ns/1ps
module tb_bsmv_engine;
   localparam int R_BLK = 2, C_BLK = 2, RC = R_BLK * C_BLK;
   localparam int VAL_W = 16, ACC_W = 32, PTR_AW = 4, BLK_AW = 6;
   localparam int VAL_AW = 8, XA_W = 6, YA_W = 6, NNZ_W = 12, CYC_W = 20;

   // {mask[28:13] (bit br*4+bc marks a present block), nbr[12:9], seed[8:1], poke[0]}
   localparam logic [28:0] CASES [6] = '{
      {16'h0001, 4'd1, 8'd3,   1'b0},
      {16'hFFFF, 4'd4, 8'd9,   1'b0},
      {16'h0F0F, 4'd4, 8'd14,  1'b1},
      {16'h8421, 4'd4, 8'd21,  1'b0},
      {16'h0030, 4'd2, 8'd6,   1'b0},
      {16'h1248, 4'd4, 8'd77,  1'b1}
   };

   logic clk = 0, rst_n = 0, start = 0;
   logic [PTR_AW-1:0] nbrows_in = '0;
   logic [NNZ_W-1:0]  nnz_in = '0;
   logic busy, done, dst_we;
   logic [NNZ_W:0]    op_count;
   logic [CYC_W-1:0]  cycle_count;
   logic [PTR_AW-1:0] ptr_addr;
   logic [BLK_AW-1:0] ptr_rdata, cidx_addr;
   logic [XA_W-1:0]   cidx_rdata, src_addr;
   logic [VAL_AW-1:0] val_addr;
   logic [VAL_W-1:0]  val_rdata, src_rdata;
   logic [YA_W-1:0]   dst_addr;
   logic [ACC_W-1:0]  dst_rdata, dst_wdata;

   logic [BLK_AW-1:0] ptr_mem  [16];
   logic [XA_W-1:0]   cidx_mem [64];
   logic [VAL_W-1:0]  val_mem  [256];
   logic [VAL_W-1:0]  src_mem  [64];
   logic [ACC_W-1:0]  dst_mem  [64];
   logic [ACC_W-1:0]  y_init   [64];
   logic [ACC_W-1:0]  y_exp    [64];
   int                wr_cnt   [64];

   int total = 0, bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   bsmv_engine dut (
      .clk(clk), .rst_n(rst_n), .start(start), .nbrows(nbrows_in), .nnz_in(nnz_in),
      .busy(busy), .done(done), .op_count(op_count), .cycle_count(cycle_count),
      .ptr_addr(ptr_addr), .ptr_rdata(ptr_rdata), .cidx_addr(cidx_addr),
      .cidx_rdata(cidx_rdata), .val_addr(val_addr), .val_rdata(val_rdata),
      .src_addr(src_addr), .src_rdata(src_rdata), .dst_addr(dst_addr),
      .dst_rdata(dst_rdata), .dst_we(dst_we), .dst_wdata(dst_wdata)
   );

   always @(posedge clk) begin
      ptr_rdata  <= ptr_mem[ptr_addr];
      cidx_rdata <= cidx_mem[cidx_addr];
      val_rdata  <= val_mem[val_addr];
      src_rdata  <= src_mem[src_addr];
      dst_rdata  <= dst_mem[dst_addr];
      if (dst_we) begin
         dst_mem[dst_addr] = dst_wdata;
         wr_cnt[dst_addr]  = wr_cnt[dst_addr] + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic clear_mems();
      for (int k = 0; k < 16; k++)  ptr_mem[k] = '0;
      for (int k = 0; k < 64; k++)  cidx_mem[k] = '0;
      for (int k = 0; k < 256; k++) val_mem[k] = '0;
      for (int k = 0; k < 64; k++) begin
         src_mem[k] = '0; dst_mem[k] = '0; y_init[k] = '0; wr_cnt[k] = 0;
      end
   endtask

   // reference: y += A*x straight from the stored blocks, 32-bit wrap
   task automatic ref_model(input int nbr);
      logic signed [31:0] p;
      for (int k = 0; k < 64; k++) y_exp[k] = y_init[k];
      for (int br = 0; br < nbr; br++)
         for (int b = int'(ptr_mem[br]); b < int'(ptr_mem[br+1]); b++)
            for (int i = 0; i < R_BLK; i++)
               for (int j = 0; j < C_BLK; j++) begin
                  p = $signed(val_mem[b*RC + i*C_BLK + j]) *
                      $signed(src_mem[int'(cidx_mem[b]) + j]);
                  y_exp[br*R_BLK + i] = y_exp[br*R_BLK + i] + p;
               end
   endtask

   function automatic int exp_cycles(input int nbr);
      int c = 1;
      for (int br = 0; br < nbr; br++)
         c += 2*R_BLK + 4 + (int'(ptr_mem[br+1]) - int'(ptr_mem[br])) * (RC + C_BLK + 4);
      return c;
   endfunction

   task automatic run(input int nbr, input int nnz, input bit poke,
                      output int dones, output int t);
      bit seen = 0;
      dones = 0; t = 0;
      @(negedge clk);
      nbrows_in = PTR_AW'(nbr); nnz_in = NNZ_W'(nnz); start = 1;
      while (!seen && t < 5000) begin
         if (poke && t == 3) begin
            start = 1; nbrows_in = '0; nnz_in = '1;
         end else if (t > 0) begin
            start = 0;
         end
         @(negedge clk); t++;
         if (t == 1) start = 0;
         if (done) begin seen = 1; dones++; end
      end
      start = 0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         if (done) dones++;
      end
      if (!seen) chk(0, "R6", "watchdog on done", t, 0);
   endtask

   initial begin
      int dones, t, nnz, nbr, nb, seed, v, mask, wsum;
      bit poke;
      clear_mems();
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(busy == 0, "R10", "busy in reset", busy, 0);
      chk(done == 0, "R10", "done in reset", done, 0);
      chk(dst_we == 0, "R10", "dst_we in reset", dst_we, 0);
      rst_n = 1;
      @(negedge clk);
      chk(op_count == 0, "R10", "op_count after reset", op_count, 0);
      chk(cycle_count == 0, "R10", "cycle_count after reset", cycle_count, 0);

      foreach (CASES[ci]) begin
         mask = int'(CASES[ci][28:13]); nbr = int'(CASES[ci][12:9]);
         seed = int'(CASES[ci][8:1]);   poke = CASES[ci][0];
         clear_mems();
         nb = 0; nnz = 0;
         for (int br = 0; br < nbr; br++) begin
            ptr_mem[br] = BLK_AW'(nb);
            for (int bc = 0; bc < 4; bc++)
               if (mask[br*4 + bc]) begin
                  cidx_mem[nb] = XA_W'(bc*C_BLK + seed % 2);
                  for (int e = 0; e < RC; e++) begin
                     v = ((seed*13 + nb*5 + e*7) % 11) - 5;
                     val_mem[nb*RC + e] = VAL_W'(v);
                     if (v != 0) nnz++;
                  end
                  nb++;
               end
         end
         ptr_mem[nbr] = BLK_AW'(nb);
         for (int k = 0; k < 64; k++) begin
            src_mem[k] = VAL_W'(((k*3 + seed) % 15) - 7);
            y_init[k]  = ACC_W'(k*1000 - 17 + seed);
            dst_mem[k] = y_init[k];
         end
         ref_model(nbr);
         run(nbr, nnz, poke, dones, t);
         for (int r = 0; r < nbr*R_BLK; r++) begin
            if (ptr_mem[r/R_BLK] == ptr_mem[r/R_BLK + 1])
               chk(dst_mem[r] == y_exp[r], "R3", "empty block row y", dst_mem[r], y_exp[r]);
            else
               chk(dst_mem[r] == y_exp[r], "R1", "y element", dst_mem[r], y_exp[r]);
            chk(wr_cnt[r] == 1, "R9", "writes per element", wr_cnt[r], 1);
         end
         chk(dst_mem[nbr*R_BLK] == y_init[nbr*R_BLK], "R9", "element past last row",
             dst_mem[nbr*R_BLK], y_init[nbr*R_BLK]);
         chk(dones == 1, poke ? "R7" : "R6", "done pulses", dones, 1);
         chk(int'(op_count) == 2*nnz, poke ? "R7" : "R4", "op_count", op_count, 2*nnz);
         chk(int'(cycle_count) == exp_cycles(nbr), poke ? "R7" : "R8", "cycle_count",
             cycle_count, exp_cycles(nbr));
      end

      // R2 / R5: extreme products wrap; unaligned column via index 1
      clear_mems();
      ptr_mem[0] = 0; ptr_mem[1] = 1; cidx_mem[0] = 1;
      for (int e = 0; e < RC; e++) val_mem[e] = 16'h8000;
      src_mem[1] = 16'h8000; src_mem[2] = 16'h8000; src_mem[0] = 16'h1234;
      dst_mem[0] = 5; dst_mem[1] = 5;
      run(1, 4, 0, dones, t);
      chk(dst_mem[0] == 32'h80000005, "R5", "wrapped sum row0", dst_mem[0], 32'h80000005);
      chk(dst_mem[1] == 32'h80000005, "R5", "wrapped sum row1", dst_mem[1], 32'h80000005);

      // R2: row-major value order, distinct weights per position
      clear_mems();
      ptr_mem[0] = 0; ptr_mem[1] = 1; cidx_mem[0] = 3;
      val_mem[0] = 1; val_mem[1] = 10; val_mem[2] = 100; val_mem[3] = 1000;
      src_mem[3] = 2; src_mem[4] = 3;
      run(1, 4, 0, dones, t);
      chk(dst_mem[0] == 32, "R2", "row0 = 1*2+10*3", dst_mem[0], 32);
      chk(dst_mem[1] == 3200, "R2", "row1 = 100*2+1000*3", dst_mem[1], 3200);
      chk(int'(op_count) == 8, "R4", "op_count with given nnz", op_count, 8);

      // R11: zero block rows
      clear_mems();
      dst_mem[0] = 42;
      run(0, 7, 0, dones, t);
      chk(t == 1, "R11", "done latency", t, 1);
      chk(dones == 1, "R11", "done pulses", dones, 1);
      wsum = 0;
      for (int k = 0; k < 64; k++) wsum += wr_cnt[k];
      chk(wsum == 0, "R11", "writes", wsum, 0);
      chk(cycle_count == 1, "R11", "cycle_count", cycle_count, 1);
      chk(dst_mem[0] == 42, "R11", "y untouched", dst_mem[0], 42);

      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL R6 global watchdog: actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule